// File: doc/BRIEF.md
# Shadowed Calendar Time Counter

This block keeps wall-clock time and date as seven live fields: seconds, minutes, hours, day of month, day of week, month and year. A single-cycle pulse on the one-second input moves the fields forward by one second. Carries ripple through all fields, and month lengths follow the calendar, including February in leap years. The year is a 7-bit offset from 1968, so it covers 128 years.

Software sets the time in two steps. First it writes the new field values over a 16-bit register bus into staging registers. The live counters do not change at this point. Then it writes the value 1 to the trigger register. A busy bit in the status register goes high for a fixed number of cycles. When the busy period ends, all staged fields load into the live counters together, in one cycle. Software polls the busy bit to learn when the new time is in effect.

Reads are combinational. The seven live fields are consecutive 16-bit slots. The seconds slot can be read again on its own afterwards: if the second read is smaller than the first, a carry happened during a multi-field read.

Top module: `rtc_shadow_cal`

## Requirements
- R1: After reset the live fields read seconds 0, minutes 0, hours 0, day of month 1, day of week 0, month 1 and year offset 0, and status bit 6 reads 0.
- R2: Each cycle with the tick input high advances the seconds. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries one into the next field.
- R3: The day of month wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in months 1, 3, 5, 7, 8, 10 and 12. That wrap increments the month. Month 12 wraps to 1 and increments the year.
- R4: February (month 2) has 29 days when the year offset is a multiple of 4, offsets 0 and 32 included, and 28 days otherwise.
- R5: The day of week advances on every day carry and wraps from 6 to 0.
- R6: A bus write to a field slot goes to a staging register only. The live field reads back unchanged until a commit.
- R7: A write of value 1 to offset 0x3C starts a commit. Status offset 0x00 reads bit 6 as 1 for BUSY_CYCLES cycles. In the cycle after the last of those cycles, every live field holds its staged value. A write of any other value to 0x3C starts nothing.
- R8: A tick in the cycle in which the staged values load is discarded. The live fields then equal the staged values exactly.
- R9: A trigger write that arrives while busy is already 1 is ignored. The busy period does not stretch.
- R10: From 23:59:59 on 31 December at year offset 127, one tick gives 00:00:00 on 1 January at year offset 0.
- R11: The live fields sit at byte offsets 0x0A (seconds), 0x0C (minutes), 0x0E (hours), 0x10 (day of month), 0x12 (day of week), 0x14 (month) and 0x16 (year), zero-extended to 16 bits. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-second advance pulse, sampled each cycle |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data for busAddr |

## Verification
The hardest case to reach from the ports is a tick that lands exactly in the load cycle. It lasts one cycle, at the end of the busy window. The bench counts cycles from the trigger write and raises the tick in that cycle, then checks that the staged values appear unchanged. Long carry chains are reached by committing times close to minute, hour, month and year boundaries, some chosen at random and some directed (leap and non-leap February, year wrap). A run of ticks follows, and a bench calendar model predicts the result.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int STAT_ADDR  = 'h00;
  localparam int BUSY_BIT   = 6;
  localparam int SLOT_BASE  = 'h0A;
  localparam int NUM_FIELDS = 7;
  localparam int TRIG_ADDR  = 'h3C;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } calTime_t;

  typedef struct packed {
    logic commit;
    logic advance;
  } calStrobe_t;

  localparam calTime_t CAL_RESET = '{yr: 7'd0, mon: 4'd1, dow: 3'd0, dom: 5'd1,
                                     hr: 5'd0, mn: 6'd0, sc: 6'd0};

  function automatic logic [4:0] monthLength(input logic [3:0] mon, input logic [6:0] yr);
    logic [4:0] len;
    case (mon)
      4'd2:                      len = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   len = 5'd30;
      default:                   len = 5'd31;
    endcase
    return len;
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic              busy,
  output calStrobe_t        strb
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             trigHit;

  assign trigHit = busWe && (busAddr == ADDR_W'(TRIG_ADDR)) && (busWdata == 16'd1);
  assign busy    = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (!busy && trigHit) begin
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  always_comb begin
    strb.commit  = (busyCnt == CNT_W'(1));
    strb.advance = secTick && !strb.commit;
  end

  // R9: a trigger during busy does not reload the countdown
  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    busy && trigHit |=> busyCnt == $past(busyCnt) - CNT_W'(1));

  // R7: busy drops right after the load cycle
  a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !busy);

  // R8: the load cycle never advances the counters
  a_r8_tick_dropped: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !strb.advance);
endmodule

// File: rtl/rtc_cal_dp.sv
module rtc_cal_dp
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic              busy,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata
);
  localparam int SLOT_END = SLOT_BASE + 2 * NUM_FIELDS;

  calTime_t   live, stage, nextTime;
  logic       slotHit;
  logic [2:0] slotIdx;
  logic [ADDR_W-1:0] slotOff;

  assign slotOff = busAddr - ADDR_W'(SLOT_BASE);
  assign slotHit = (busAddr >= ADDR_W'(SLOT_BASE)) && (busAddr < ADDR_W'(SLOT_END)) && !busAddr[0];
  assign slotIdx = slotOff[3:1];

  // one-second carry chain
  always_comb begin
    nextTime = live;
    if (live.sc != 6'd59) begin
      nextTime.sc = live.sc + 6'd1;
    end else begin
      nextTime.sc = '0;
      if (live.mn != 6'd59) begin
        nextTime.mn = live.mn + 6'd1;
      end else begin
        nextTime.mn = '0;
        if (live.hr != 5'd23) begin
          nextTime.hr = live.hr + 5'd1;
        end else begin
          nextTime.hr  = '0;
          nextTime.dow = (live.dow == 3'd6) ? 3'd0 : live.dow + 3'd1;
          if (live.dom != monthLength(live.mon, live.yr)) begin
            nextTime.dom = live.dom + 5'd1;
          end else begin
            nextTime.dom = 5'd1;
            if (live.mon != 4'd12) begin
              nextTime.mon = live.mon + 4'd1;
            end else begin
              nextTime.mon = 4'd1;
              nextTime.yr  = live.yr + 7'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= CAL_RESET;
    end else if (busWe && slotHit) begin
      case (slotIdx)
        3'd0:    stage.sc  <= busWdata[5:0];
        3'd1:    stage.mn  <= busWdata[5:0];
        3'd2:    stage.hr  <= busWdata[4:0];
        3'd3:    stage.dom <= busWdata[4:0];
        3'd4:    stage.dow <= busWdata[2:0];
        3'd5:    stage.mon <= busWdata[3:0];
        default: stage.yr  <= busWdata[6:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             live <= CAL_RESET;
    else if (strb.commit)  live <= stage;
    else if (strb.advance) live <= nextTime;
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(STAT_ADDR)) begin
      busRdata[BUSY_BIT] = busy;
    end else if (slotHit) begin
      case (slotIdx)
        3'd0:    busRdata = 16'(live.sc);
        3'd1:    busRdata = 16'(live.mn);
        3'd2:    busRdata = 16'(live.hr);
        3'd3:    busRdata = 16'(live.dom);
        3'd4:    busRdata = 16'(live.dow);
        3'd5:    busRdata = 16'(live.mon);
        default: busRdata = 16'(live.yr);
      endcase
    end
  end

  // R6: without load or tick the live time holds
  a_r6_live_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit && !strb.advance |=> $stable(live));

  // R7: load takes exactly the staged value
  a_r7_commit_loads: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> live == $past(stage));

  // R2: an advance with seconds below 59 changes only the seconds
  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && live.sc < 6'd59 |=> live.sc == $past(live.sc) + 6'd1 && live.mn == $past(live.mn));

  // R5: day of week steps on a day carry
  a_r5_dow_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && live.sc == 6'd59 && live.mn == 6'd59 && live.hr == 5'd23 && live.dow < 3'd6
    |=> live.dow == $past(live.dow) + 3'd1);
endmodule

// File: rtl/rtc_shadow_cal.sv
module rtc_shadow_cal
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata
);
  calStrobe_t strb;
  logic       busy;

  rtc_cal_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busy(busy), .strb(strb)
  );

  rtc_cal_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );
endmodule

// File: tb/sim_rtc_shadow_cal.sv
module sim_rtc_shadow_cal;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 7;
  localparam int BUSY       = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              secTick = 1'b0;
  logic              busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [15:0]       busWdata = '0;
  logic [15:0]       busRdata;

  int checks = 0;
  int failures = 0;
  int model [7];

  rtc_shadow_cal #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  function automatic int daysIn(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    model[0]++;
    if (model[0] == 60) begin
      model[0] = 0; model[1]++;
      if (model[1] == 60) begin
        model[1] = 0; model[2]++;
        if (model[2] == 24) begin
          model[2] = 0;
          model[4] = (model[4] + 1) % 7;
          model[3]++;
          if (model[3] > daysIn(model[5], model[6])) begin
            model[3] = 1; model[5]++;
            if (model[5] == 13) begin
              model[5] = 1; model[6] = (model[6] + 1) % 128;
            end
          end
        end
      end
    end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readReg(int addr, output int val);
    busAddr = ADDR_W'(addr);
    #1;
    val = int'(busRdata);
  endtask

  task automatic busWrite(int addr, int data);
    @(negedge clk);
    busWe = 1'b1; busAddr = ADDR_W'(addr); busWdata = 16'(data);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic checkAll(string req);
    int v;
    for (int i = 0; i < 7; i++) begin
      readReg('h0A + 2 * i, v);
      check(req, v, model[i]);
    end
  endtask

  task automatic stageAll(int f [7]);
    for (int i = 0; i < 7; i++) busWrite('h0A + 2 * i, f[i]);
  endtask

  task automatic commitAll(int f [7]);
    stageAll(f);
    busWrite('h3C, 1);
    repeat (BUSY) @(negedge clk);
    for (int i = 0; i < 7; i++) model[i] = f[i];
  endtask

  task automatic doTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
      modelTick();
    end
  endtask

  initial begin
    int v;
    int f [7];
    void'($urandom(32'd2024));
    model = '{0, 0, 0, 1, 0, 1, 0};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values, R11 slot layout
    checkAll("R1");
    readReg('h00, v); check("R1 busy", v, 0);
    readReg('h30, v); check("R11 unmapped", v, 0);

    // R2 seconds advance
    doTicks(3);
    checkAll("R2");

    // R6 staging only
    f = '{12, 34, 5, 6, 3, 7, 40};
    stageAll(f);
    repeat (3) @(negedge clk);
    checkAll("R6");

    // R7 non-1 trigger value ignored
    busWrite('h3C, 2);
    readReg('h00, v); check("R7 bad trigger busy", v, 0);
    repeat (BUSY + 1) @(negedge clk);
    checkAll("R7 bad trigger");

    // R7 busy window then load; R9 retrigger ignored
    busWrite('h3C, 1);
    readReg('h00, v); check("R7 busy set", v, 64);
    busWrite('h3C, 1);
    readReg('h00, v); check("R9 busy mid", v, 64);
    @(negedge clk);
    readReg('h00, v); check("R7 busy last", v, 64);
    readReg('h0A, v); check("R7 not yet loaded", v, 3);
    @(negedge clk);
    readReg('h00, v); check("R9 busy cleared", v, 0);
    for (int i = 0; i < 7; i++) model[i] = f[i];
    checkAll("R7 loaded");

    // R8 tick in load cycle dropped
    f = '{59, 59, 23, 31, 6, 12, 10};
    stageAll(f);
    busWrite('h3C, 1);
    repeat (BUSY - 1) @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    for (int i = 0; i < 7; i++) model[i] = f[i];
    checkAll("R8");

    // R3 and R5: year-end carry, day of week 6 to 0
    doTicks(1);
    checkAll("R3 R5 year carry");

    // R3 30-day month
    f = '{59, 59, 23, 30, 2, 4, 5};
    commitAll(f); doTicks(1); checkAll("R3 April end");

    // R4 leap Feb at offset 0 and 32, non-leap at 1
    f = '{59, 59, 23, 28, 0, 2, 0};
    commitAll(f); doTicks(1); checkAll("R4 leap day 29");
    f = '{59, 59, 23, 29, 0, 2, 32};
    commitAll(f); doTicks(1); checkAll("R4 leap offset 32");
    f = '{59, 59, 23, 28, 0, 2, 1};
    commitAll(f); doTicks(1); checkAll("R4 non-leap");

    // R10 full wrap
    f = '{59, 59, 23, 31, 1, 12, 127};
    commitAll(f); doTicks(1); checkAll("R10");

    // random near-boundary runs
    for (int it = 0; it < 20; it++) begin
      int mon, yr;
      mon = $urandom_range(12, 1);
      yr  = $urandom_range(127, 0);
      f[0] = $urandom_range(59, 40);
      f[1] = $urandom_range(59, 55);
      f[2] = $urandom_range(23, 22);
      f[3] = daysIn(mon, yr) - $urandom_range(1, 0);
      f[4] = $urandom_range(6, 0);
      f[5] = mon;
      f[6] = yr;
      commitAll(f);
      doTicks($urandom_range(400, 1));
      checkAll("R2 R3 R4 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule